// File: doc/BRIEF.md
# Ternary PN Matched Filter Correlator

This block correlates a complex baseband stream against a stored spreading code. Each channel carries 3-bit samples that arrive two per chip and are marked by a sample strobe. The samples first pass through a front-end averager that adds each sample to the one before it and rounds the result without bias. The averaged codes then enter two tapped delay lines, one for I and one for Q. Taps sit two samples apart, so 64 taps cover 64 chips. Each tap is weighted by +1, -1 or 0. The weights come from one of two coefficient banks: an acquisition bank used while the receiver searches for the preamble, and a data bank used after lock.

On every accepted sample the block registers three results. The first is a 10-bit signed correlation sum per channel. The second is an 8-bit saturating window of each sum. The third is a 10-bit approximate magnitude, which a later symbol detector compares against a threshold. Coefficients are written one tap at a time through a plain parallel write port. A 7-bit mask removes groups of 7 taps from the sum, which lets shorter codes leave the far end of the line unused.

Top module: `ternary_correlator`

## Requirements
- R1: After reset the following hold:
  - every output is zero and `outValid` is low;
  - the acquisition bank is selected;
  - every delay-line entry holds code 0;
  - the previous-sample registers hold code 0;
  - the rounding flag is clear.
- R2: A 3-bit two's complement sample code c stands for the level 2c+1 (odd values -7..+7).
  - With the averager active, v = c_now + c_prev + 1 is formed, where c_prev is the code accepted just before.
  - An odd v is kept as the level.
  - An even v becomes v+1 when the rounding flag is clear and v-1 when it is set.
  - The flag inverts on every accepted sample, so rounding alternates between up and down.
- R3: With `averBypass` high, the level entering the delay line is 2c+1 of the current sample. The previous-sample register and the rounding flag still update.
- R4: Each channel sum is the sum over taps n = 0..63 of level(n) × weight(n). Level(n) is the averager output produced 2n accepted samples earlier, so tap 0 holds the newest sample.
- R5: Coefficient codes map as follows:
  - 2'b01 is +1;
  - 2'b11 is -1;
  - 2'b00 and 2'b10 are both 0.
- R6: `lockDet` selects the data bank and `reAcq` selects the acquisition bank. `reAcq` wins when both are high in the same cycle. A bank change made in the same cycle as a sample applies to that sample's result.
- R7: `outValid` is high for exactly the one cycle after each cycle with `sampleEn` high. The sums, windows and magnitude change only when `outValid` rises.
- R8: When bit g of `groupOff` is set, taps 63-7g-6 through 63-7g add nothing to the sum. Taps 0..14 are never gated.
- R9: The 8-bit window is the sum arithmetically shifted right by s, where s = `viewSel` for values 0..2 and s = 2 for a value of 3. The result saturates to +127 or -128.
- R10: The magnitude is max(|I|,|Q|) + floor(min(|I|,|Q|)/2), limited to 1023.
- R11: With `coefWr` high, the code on `coefCode` is written to tap `coefAddr` of the bank named by `coefBank` (0 for acquisition, 1 for data). The new code applies to the next sample's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Baseband sample strobe |
| sampI | input | 3 | I sample code, two's complement |
| sampQ | input | 3 | Q sample code, two's complement |
| averBypass | input | 1 | Skip the front-end averager |
| lockDet | input | 1 | Switch to the data coefficient bank |
| reAcq | input | 1 | Return to the acquisition bank |
| coefWr | input | 1 | Coefficient write strobe |
| coefBank | input | 1 | Bank to write, 0 acquisition, 1 data |
| coefAddr | input | 6 | Tap index to write |
| coefCode | input | 2 | Ternary code to write |
| groupOff | input | 7 | Tap group gating mask |
| viewSel | input | 2 | Window shift select |
| sumI | output | 10 | I correlation sum |
| sumQ | output | 10 | Q correlation sum |
| viewI | output | 8 | Saturated I window |
| viewQ | output | 8 | Saturated Q window |
| mag | output | 10 | Approximate magnitude |
| outValid | output | 1 | Result strobe |

## Verification
A bank switch and a sample acceptance can land in the same cycle. The bench provokes this by raising `lockDet` together with `sampleEn`, and judges the result correct only if that sample's sums are weighted by the data bank. It also raises `lockDet` and `reAcq` together and checks that the next result uses the acquisition bank. A coefficient write followed directly by a sample is judged the same way: the rewritten tap must already appear in that sample's sum.

// File: rtl/corr_pkg.sv
package corr_pkg;

  typedef enum logic {
    BANK_ACQ  = 1'b0,
    BANK_DATA = 1'b1
  } bank_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic  shiftEn;  // accept a sample into the averager and delay lines
    logic  sumEn;    // register the sums one cycle later
    bank_e bankSel;  // coefficient bank feeding the adders
    logic  roundUp;  // direction for rounding an even averager value
  } corr_strb_t;

  localparam logic [1:0] COEF_PLUS  = 2'b01;
  localparam logic [1:0] COEF_MINUS = 2'b11;

endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       lockDet,
  input  logic       reAcq,
  output corr_strb_t strb
);

  logic  togQ;
  logic  sumEnQ;
  bank_e bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      togQ   <= 1'b0;
      sumEnQ <= 1'b0;
      bankQ  <= BANK_ACQ;
    end else begin
      sumEnQ <= sampleEn;
      if (sampleEn) togQ <= ~togQ;
      if (reAcq)        bankQ <= BANK_ACQ;
      else if (lockDet) bankQ <= BANK_DATA;
    end
  end

  assign strb.shiftEn = sampleEn;
  assign strb.sumEn   = sumEnQ;
  assign strb.bankSel = bankQ;
  assign strb.roundUp = ~togQ;

  // R6: a return to acquisition has priority over a lock
  assert_reacq_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    reAcq |=> (bankQ == BANK_ACQ));

  // R6: a lock alone moves to the data bank
  assert_lock_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockDet && !reAcq) |=> (bankQ == BANK_DATA));

  // R6: with no request the bank holds
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!lockDet && !reAcq) |=> $stable(bankQ));

endmodule

// File: rtl/corr_fep.sv
module corr_fep #(
  parameter int SAMP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              bypass,
  input  logic              roundUp,
  input  logic [SAMP_W-1:0] sampIn,
  output logic [SAMP_W-1:0] codeOut
);

  localparam int LVL_W = SAMP_W + 1;

  logic [SAMP_W-1:0]       prevQ;
  logic signed [LVL_W-1:0] curX;
  logic signed [LVL_W-1:0] prevX;
  logic signed [LVL_W-1:0] sumV;
  logic [SAMP_W-1:0]       halfV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   prevQ <= '0;
    else if (en) prevQ <= sampIn;
  end

  assign curX  = {sampIn[SAMP_W-1], sampIn};
  assign prevX = {prevQ[SAMP_W-1], prevQ};
  // sum of two odd levels, halved: v = c + p + 1
  assign sumV  = curX + prevX + LVL_W'(1);
  assign halfV = sumV[LVL_W-1:1];

  // odd v keeps its code; even v steps up or down by one level
  always_comb begin
    if (bypass)                   codeOut = sampIn;
    else if (sumV[0] || roundUp)  codeOut = halfV;
    else                          codeOut = halfV - SAMP_W'(1);
  end

  // R2: averaging two equal samples leaves the value unchanged
  assert_fep_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (en && !bypass && (sampIn == prevQ)) |-> (codeOut == sampIn));

endmodule

// File: rtl/corr_dp.sv
module corr_dp
  import corr_pkg::*;
#(
  parameter int NUM_TAPS    = 64,
  parameter int SAMP_W      = 3,
  parameter int TAP_SPACING = 2,
  parameter int SUM_W       = 10,
  parameter int VIEW_W      = 8,
  parameter int MAG_W       = 10,
  parameter int GROUP_SIZE  = 7,
  parameter int NUM_GROUPS  = 7,
  localparam int ADDR_W     = $clog2(NUM_TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  corr_strb_t               strb,
  input  logic                     averBypass,
  input  logic [SAMP_W-1:0]        sampI,
  input  logic [SAMP_W-1:0]        sampQ,
  input  logic                     coefWr,
  input  logic                     coefBank,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic [1:0]               coefCode,
  input  logic [NUM_GROUPS-1:0]    groupOff,
  input  logic [1:0]               viewSel,
  output logic signed [SUM_W-1:0]  sumI,
  output logic signed [SUM_W-1:0]  sumQ,
  output logic [VIEW_W-1:0]        viewI,
  output logic [VIEW_W-1:0]        viewQ,
  output logic [MAG_W-1:0]         mag,
  output logic                     outValid
);

  localparam int DLY_LEN    = (NUM_TAPS - 1) * TAP_SPACING + 1;
  localparam int GATE_START = NUM_TAPS - NUM_GROUPS * GROUP_SIZE;
  localparam int MAX_SHIFT  = SUM_W - VIEW_W;
  localparam logic signed [SUM_W-1:0] VMAX = SUM_W'((1 << (VIEW_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] VMIN = ~VMAX;
  localparam logic [SUM_W:0] MAG_MAX = (SUM_W + 1)'((1 << MAG_W) - 1);

  // ---------------- front end ----------------
  logic [SAMP_W-1:0] fepIn   [2];
  logic [SAMP_W-1:0] fepCode [2];

  assign fepIn[0] = sampI;
  assign fepIn[1] = sampQ;

  for (genvar ch = 0; ch < 2; ch++) begin : g_fep
    corr_fep #(.SAMP_W(SAMP_W)) u_fep (
      .clk     (clk),
      .rstN    (rstN),
      .en      (strb.shiftEn),
      .bypass  (averBypass),
      .roundUp (strb.roundUp),
      .sampIn  (fepIn[ch]),
      .codeOut (fepCode[ch])
    );
  end

  // ---------------- delay lines (codes, not levels) ----------------
  logic [SAMP_W-1:0] dlyI [DLY_LEN];
  logic [SAMP_W-1:0] dlyQ [DLY_LEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DLY_LEN; k++) begin
        dlyI[k] <= '0;
        dlyQ[k] <= '0;
      end
    end else if (strb.shiftEn) begin
      dlyI[0] <= fepCode[0];
      dlyQ[0] <= fepCode[1];
      for (int k = 1; k < DLY_LEN; k++) begin
        dlyI[k] <= dlyI[k-1];
        dlyQ[k] <= dlyQ[k-1];
      end
    end
  end

  // ---------------- coefficient banks ----------------
  logic [1:0] coefMem [2][NUM_TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int n = 0; n < NUM_TAPS; n++) coefMem[b][n] <= '0;
    end else if (coefWr) begin
      coefMem[coefBank][coefAddr] <= coefCode;
    end
  end

  // ---------------- tap gating ----------------
  logic [NUM_TAPS-1:0] tapOff;

  for (genvar n = 0; n < NUM_TAPS; n++) begin : g_gate
    if (n >= GATE_START) begin : g_on
      assign tapOff[n] = groupOff[(NUM_TAPS - 1 - n) / GROUP_SIZE];
    end else begin : g_fixed
      assign tapOff[n] = 1'b0;
    end
  end

  // ---------------- adders ----------------
  function automatic logic signed [SUM_W-1:0] levelOf(input logic [SAMP_W-1:0] c);
    return {{(SUM_W - SAMP_W - 1){c[SAMP_W-1]}}, c, 1'b1};
  endfunction

  logic                    bankBit;
  logic signed [SUM_W-1:0] accI;
  logic signed [SUM_W-1:0] accQ;

  assign bankBit = strb.bankSel;

  always_comb begin
    accI = '0;
    accQ = '0;
    for (int n = 0; n < NUM_TAPS; n++) begin
      if (!tapOff[n]) begin
        if (coefMem[bankBit][n] == COEF_PLUS) begin
          accI = accI + levelOf(dlyI[n*TAP_SPACING]);
          accQ = accQ + levelOf(dlyQ[n*TAP_SPACING]);
        end else if (coefMem[bankBit][n] == COEF_MINUS) begin
          accI = accI - levelOf(dlyI[n*TAP_SPACING]);
          accQ = accQ - levelOf(dlyQ[n*TAP_SPACING]);
        end
      end
    end
  end

  // ---------------- window and magnitude ----------------
  logic [1:0] shAmt;
  assign shAmt = (int'(viewSel) > MAX_SHIFT) ? 2'(MAX_SHIFT) : viewSel;

  function automatic logic [VIEW_W-1:0] windowOf(input logic signed [SUM_W-1:0] s,
                                                 input logic [1:0] sh);
    logic signed [SUM_W-1:0] t;
    t = s >>> sh;
    if (t > VMAX)      return VMAX[VIEW_W-1:0];
    else if (t < VMIN) return VMIN[VIEW_W-1:0];
    else               return t[VIEW_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] absOf(input logic signed [SUM_W-1:0] s);
    return s[SUM_W-1] ? SUM_W'(-s) : SUM_W'(s);
  endfunction

  logic [SUM_W-1:0] absI, absQ, maxV, minV;
  logic [SUM_W:0]   rawMag;
  logic [MAG_W-1:0] magNext;

  always_comb begin
    absI    = absOf(accI);
    absQ    = absOf(accQ);
    maxV    = (absI > absQ) ? absI : absQ;
    minV    = (absI > absQ) ? absQ : absI;
    rawMag  = {1'b0, maxV} + {2'b00, minV[SUM_W-1:1]};
    magNext = (rawMag > MAG_MAX) ? MAG_W'(MAG_MAX) : MAG_W'(rawMag);
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumI     <= '0;
      sumQ     <= '0;
      viewI    <= '0;
      viewQ    <= '0;
      mag      <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.sumEn;
      if (strb.sumEn) begin
        sumI  <= accI;
        sumQ  <= accQ;
        viewI <= windowOf(accI, shAmt);
        viewQ <= windowOf(accQ, shAmt);
        mag   <= magNext;
      end
    end
  end

  // R7: results only move on a valid cycle
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(sumI) && $stable(sumQ) && $stable(mag)));

  // R9: the window keeps the sign of its sum
  assert_view_sign_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((viewI[VIEW_W-1] == sumI[SUM_W-1]) && (viewQ[VIEW_W-1] == sumQ[SUM_W-1])));

  // R10: magnitude lies between the larger component and the component sum
  assert_mag_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((int'(mag) >= int'(absOf(sumI))) && (int'(mag) >= int'(absOf(sumQ)))
                  && (int'(mag) <= int'(absOf(sumI)) + int'(absOf(sumQ)))));

endmodule

// File: rtl/ternary_correlator.sv
module ternary_correlator
  import corr_pkg::*;
#(
  parameter int NUM_TAPS    = 64,
  parameter int SAMP_W      = 3,
  parameter int TAP_SPACING = 2,
  parameter int SUM_W       = 10,
  parameter int VIEW_W      = 8,
  parameter int MAG_W       = 10,
  parameter int GROUP_SIZE  = 7,
  parameter int NUM_GROUPS  = 7,
  localparam int ADDR_W     = $clog2(NUM_TAPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleEn,
  input  logic [SAMP_W-1:0]       sampI,
  input  logic [SAMP_W-1:0]       sampQ,
  input  logic                    averBypass,
  input  logic                    lockDet,
  input  logic                    reAcq,
  input  logic                    coefWr,
  input  logic                    coefBank,
  input  logic [ADDR_W-1:0]       coefAddr,
  input  logic [1:0]              coefCode,
  input  logic [NUM_GROUPS-1:0]   groupOff,
  input  logic [1:0]              viewSel,
  output logic signed [SUM_W-1:0] sumI,
  output logic signed [SUM_W-1:0] sumQ,
  output logic [VIEW_W-1:0]       viewI,
  output logic [VIEW_W-1:0]       viewQ,
  output logic [MAG_W-1:0]        mag,
  output logic                    outValid
);

  corr_strb_t strb;

  corr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .lockDet  (lockDet),
    .reAcq    (reAcq),
    .strb     (strb)
  );

  corr_dp #(
    .NUM_TAPS    (NUM_TAPS),
    .SAMP_W      (SAMP_W),
    .TAP_SPACING (TAP_SPACING),
    .SUM_W       (SUM_W),
    .VIEW_W      (VIEW_W),
    .MAG_W       (MAG_W),
    .GROUP_SIZE  (GROUP_SIZE),
    .NUM_GROUPS  (NUM_GROUPS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .averBypass (averBypass),
    .sampI      (sampI),
    .sampQ      (sampQ),
    .coefWr     (coefWr),
    .coefBank   (coefBank),
    .coefAddr   (coefAddr),
    .coefCode   (coefCode),
    .groupOff   (groupOff),
    .viewSel    (viewSel),
    .sumI       (sumI),
    .sumQ       (sumQ),
    .viewI      (viewI),
    .viewQ      (viewQ),
    .mag        (mag),
    .outValid   (outValid)
  );

endmodule

// File: tb/tb_ternary_correlator.sv
module tb_ternary_correlator;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 64;
  localparam int DL = 127;
  localparam int NVEC = 24;

  logic              clk = 1'b0;
  logic              rstN;
  logic              sampleEn, averBypass, lockDet, reAcq;
  logic [2:0]        sampI, sampQ;
  logic              coefWr, coefBank;
  logic [5:0]        coefAddr;
  logic [1:0]        coefCode;
  logic [6:0]        groupOff;
  logic [1:0]        viewSel;
  logic signed [9:0] sumI, sumQ;
  logic signed [7:0] viewI, viewQ;
  logic [9:0]        mag;
  logic              outValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  ternary_correlator dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .sampI(sampI), .sampQ(sampQ),
    .averBypass(averBypass), .lockDet(lockDet), .reAcq(reAcq),
    .coefWr(coefWr), .coefBank(coefBank), .coefAddr(coefAddr), .coefCode(coefCode),
    .groupOff(groupOff), .viewSel(viewSel),
    .sumI(sumI), .sumQ(sumQ), .viewI(viewI), .viewQ(viewQ), .mag(mag), .outValid(outValid)
  );

  // stimulus: {bypass, viewSel[1:0], I code[2:0], Q code[2:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 3'd3, 3'd5}, {1'b0, 2'd1, 3'd1, 3'd1}, {1'b0, 2'd2, 3'd7, 3'd0},
    {1'b0, 2'd3, 3'd4, 3'd4}, {1'b0, 2'd0, 3'd2, 3'd6}, {1'b0, 2'd1, 3'd0, 3'd3},
    {1'b1, 2'd2, 3'd3, 3'd4}, {1'b1, 2'd0, 3'd5, 3'd2}, {1'b0, 2'd0, 3'd6, 3'd7},
    {1'b0, 2'd1, 3'd3, 3'd3}, {1'b0, 2'd2, 3'd3, 3'd1}, {1'b0, 2'd0, 3'd4, 3'd5},
    {1'b1, 2'd3, 3'd0, 3'd7}, {1'b0, 2'd0, 3'd1, 3'd2}, {1'b0, 2'd1, 3'd2, 3'd3},
    {1'b0, 2'd2, 3'd5, 3'd4}, {1'b1, 2'd0, 3'd7, 3'd1}, {1'b0, 2'd0, 3'd0, 3'd0},
    {1'b0, 2'd1, 3'd6, 3'd6}, {1'b0, 2'd2, 3'd1, 3'd7}, {1'b0, 2'd0, 3'd2, 3'd5},
    {1'b1, 2'd1, 3'd4, 3'd3}, {1'b0, 2'd0, 3'd3, 3'd2}, {1'b0, 2'd3, 3'd5, 3'd6}
  };

  int   nChk = 0, nFail = 0;
  bit   done = 0;
  int   prevI, prevQ, tog, bank;
  int   dI [DL];
  int   dQ [DL];
  logic [1:0] cm [2][NT];

  function automatic int codeVal(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic bit offTap(int n);
    if (n < 15) return 1'b0;
    return groupOff[(63 - n) / 7];
  endfunction

  function automatic int expSum(bit isQ);
    int s = 0;
    for (int n = 0; n < NT; n++)
      if (!offTap(n)) s += (isQ ? dQ[2*n] : dI[2*n]) * codeVal(cm[bank][n]);
    return s;
  endfunction

  function automatic int expView(int s, int sel);
    int sh = (sel > 2) ? 2 : sel;
    int t = s >>> sh;
    if (t > 127) return 127;
    if (t < -128) return -128;
    return t;
  endfunction

  function automatic int expMag(int a, int b);
    int x = (a < 0) ? -a : a;
    int y = (b < 0) ? -b : b;
    int mx = (x > y) ? x : y;
    int mn = (x > y) ? y : x;
    int m = mx + (mn >> 1);
    return (m > 1023) ? 1023 : m;
  endfunction

  function automatic int fepLvl(int c, int p, bit byp);
    int v;
    if (byp) return 2*c + 1;
    v = c + p + 1;
    if (v % 2 != 0) return v;
    return (tog == 0) ? v + 1 : v - 1;
  endfunction

  function automatic logic [1:0] acqCode(int n);
    if (n % 7 == 6) return 2'b10;
    if (n % 3 == 0) return 2'b01;
    if (n % 3 == 1) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [1:0] dataCode(int n);
    if (n == 5) return 2'b10;
    return (n % 2 == 1) ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCoef(int b, int a, logic [1:0] c);
    @(negedge clk);
    coefWr = 1'b1; coefBank = b[0]; coefAddr = a[5:0]; coefCode = c;
    @(negedge clk);
    coefWr = 1'b0;
    cm[b][a] = c;
  endtask

  task automatic pulseCtl(bit l, bit r);
    @(negedge clk);
    lockDet = l; reAcq = r;
    @(negedge clk);
    lockDet = 1'b0; reAcq = 1'b0;
    if (r) bank = 0; else if (l) bank = 1;
  endtask

  // sample accepted at edge k, result registered at edge k+1, checked after it
  task automatic doSample(int ci, int cq, bit l = 0, bit r = 0);
    int li, lq;
    @(negedge clk);
    sampleEn = 1'b1; sampI = ci[2:0]; sampQ = cq[2:0]; lockDet = l; reAcq = r;
    @(negedge clk);
    sampleEn = 1'b0; lockDet = 1'b0; reAcq = 1'b0;
    if (r) bank = 0; else if (l) bank = 1;
    li = fepLvl(ci, prevI, averBypass);
    lq = fepLvl(cq, prevQ, averBypass);
    prevI = ci; prevQ = cq; tog ^= 1;
    for (int k = DL - 1; k > 0; k--) begin
      dI[k] = dI[k-1];
      dQ[k] = dQ[k-1];
    end
    dI[0] = li; dQ[0] = lq;
    @(negedge clk);
  endtask

  task automatic checkOut(string req);
    int ei = expSum(0);
    int eq = expSum(1);
    chk({req, " R7 outValid"}, int'(outValid), 1);
    chk({req, " R4 sumI"}, int'(sumI), ei);
    chk({req, " R4 sumQ"}, int'(sumQ), eq);
    chk({req, " R9 viewI"}, int'(viewI), expView(ei, int'(viewSel)));
    chk({req, " R9 viewQ"}, int'(viewQ), expView(eq, int'(viewSel)));
    chk({req, " R10 mag"}, int'(mag), expMag(ei, eq));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int held;
    rstN = 1'b0; sampleEn = 0; averBypass = 0; lockDet = 0; reAcq = 0;
    sampI = 0; sampQ = 0; coefWr = 0; coefBank = 0; coefAddr = 0; coefCode = 0;
    groupOff = 0; viewSel = 0;
    prevI = 0; prevQ = 0; tog = 0; bank = 0;
    for (int k = 0; k < DL; k++) begin dI[k] = 1; dQ[k] = 1; end
    for (int b = 0; b < 2; b++) for (int n = 0; n < NT; n++) cm[b][n] = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 sumI", int'(sumI), 0);
    chk("R1 sumQ", int'(sumQ), 0);
    chk("R1 viewI", int'(viewI), 0);
    chk("R1 mag", int'(mag), 0);

    // R11 load both banks; the acquisition bank holds code 2'b10 taps (R5)
    for (int n = 0; n < NT; n++) begin
      writeCoef(0, n, acqCode(n));
      writeCoef(1, n, dataCode(n));
    end

    // table walk: R2 averaging, R3 bypass, R5 codes, R4/R9/R10 outputs
    for (int v = 0; v < NVEC; v++) begin
      averBypass = VEC[v][8];
      viewSel    = VEC[v][7:6];
      doSample(int'($signed(VEC[v][5:3])), int'($signed(VEC[v][2:0])));
      checkOut(VEC[v][8] ? "R3 R5" : "R2 R5");
    end
    averBypass = 1'b0;

    // R7 no result and no change in a cycle without a sample
    held = int'(sumI);
    @(negedge clk);
    chk("R7 outValid idle", int'(outValid), 0);
    chk("R7 sumI held", int'(sumI), held);

    // R8 tap group gating
    groupOff = 7'b1000001;
    doSample(2, -3);
    checkOut("R8");
    groupOff = 7'b0111110;
    doSample(-1, 1);
    checkOut("R8");
    groupOff = 7'b0000000;

    // R11 a write to the idle bank has no effect, a write to the live bank does
    writeCoef(1, 0, 2'b11);
    doSample(1, 1);
    checkOut("R11 idle bank");
    writeCoef(0, 0, 2'b11);
    doSample(-2, 3);
    checkOut("R11 live bank");

    // R6 lock in the same cycle as a sample, then priority of reAcq
    doSample(3, 0, 1, 0);
    checkOut("R6 lock with sample");
    doSample(-1, 2);
    checkOut("R6 data bank");
    pulseCtl(1, 1);
    doSample(0, -4);
    checkOut("R6 reAcq priority");
    pulseCtl(1, 0);
    doSample(2, 2);
    checkOut("R6 lock pulse");
    pulseCtl(0, 1);
    doSample(-3, 1);
    checkOut("R6 reAcq pulse");

    // full-scale fill for R9 saturation and R10 magnitude
    for (int n = 0; n < NT; n++) writeCoef(0, n, 2'b01);
    averBypass = 1'b1;
    viewSel = 2'd0;
    for (int s = 0; s < DL; s++) begin
      doSample(3, -4);
      checkOut("R9 fill");
    end
    chk("R4 full-scale sumI", int'(sumI), 448);
    chk("R4 full-scale sumQ", int'(sumQ), -448);
    chk("R9 sel0 viewI", int'(viewI), 127);
    chk("R9 sel0 viewQ", int'(viewQ), -128);
    chk("R10 full-scale mag", int'(mag), 672);
    viewSel = 2'd1;
    doSample(3, -4);
    chk("R9 sel1 viewI", int'(viewI), 127);
    chk("R9 sel1 viewQ", int'(viewQ), -128);
    viewSel = 2'd2;
    doSample(3, -4);
    chk("R9 sel2 viewI", int'(viewI), 112);
    chk("R9 sel2 viewQ", int'(viewQ), -112);
    viewSel = 2'd3;
    doSample(3, -4);
    chk("R9 sel3 viewI", int'(viewI), 112);
    chk("R9 sel3 viewQ", int'(viewQ), -112);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule